// File: doc/BRIEF.md
# Sequential Buffer RAM Access Port

This block gives a host a narrow I/O window into a 2048-byte buffer RAM. Instead of mapping every RAM byte into the host address space, the host loads an 11-bit pointer through two byte-wide registers and then moves data through a single data register. When stepping is turned on, the pointer advances after every data access, so the host can stream a whole buffer with no further pointer writes.

Data moves either one byte at a time or as a 16-bit word. Word accesses ignore pointer bit 0, carry the even byte in the low lane and the odd byte in the high lane, and advance the pointer by two. Reads are served from a one-word prefetch buffer. A small controller refills that buffer when the host selects read direction and when a stepping read moves the pointer.

The controller has two states. `ST_IDLE` is the resting state. `ST_FETCH` is the single cycle in which the RAM word at the pointer is captured into the buffer. The transition `ST_IDLE -> ST_FETCH` is taken on a trigger, which is either a pointer-high write with the direction bit set or a data read with stepping on. The transition `ST_FETCH -> ST_IDLE` follows when no new trigger arrives. The transition `ST_FETCH -> ST_FETCH` is taken on a back-to-back trigger.

Top module: `seq_ram_port`

## Requirements
- R1: After reset, the pointer is 000H, and the stepping and direction bits are 0. Both pointer registers read back 00H.
- R2: Offset 0EH holds pointer bits 7..0. Offset 0FH holds pointer bits 10..8 in bits 2..0, stepping enable in bit 7 and read direction in bit 6. Bits 5..3 of 0FH read 0. Both registers read back what was loaded.
- R3: A byte write at offset 0CH stores io_wdata[7:0] at the pointer. A byte read at 0CH returns the byte at the pointer on io_rdata[7:0], with io_rdata[15:8] = 0.
- R4: With stepping on, every byte data access adds 1 to the pointer. The pointer wraps from 7FFH to 000H.
- R5: A word access at 0CH (io_wide=1) uses the pointer with bit 0 forced to 0. The even byte is on bits 7..0 and the odd byte on bits 15..8. With stepping on, the pointer becomes the next even address, and 7FEH or 7FFH steps to 000H.
- R6: With stepping off, a data access leaves the pointer unchanged, and repeated reads return the same data.
- R7: A write to 0FH with bit 6 set loads the buffer from the new pointer. A data read made from the second clock after that write returns the RAM contents at the pointer.
- R8: An access at offset 0DH alone, or at any offset other than 0CH, 0EH or 0FH, changes neither the RAM nor the pointer. io_rdata reads 0 at the unused offsets.
- R9: A data read with stepping on refills the buffer from the advanced pointer, so reads spaced two clocks apart stream consecutive data.
- R10: Writing 0EH does not refill the buffer. A later read without a trigger returns the lane of the previously buffered word that the new pointer bit 0 selects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_off | input | 4 | Register offset within the I/O window |
| io_wide | input | 1 | 1 selects a 16-bit data access |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data of the addressed register, combinational |

## Verification
The hardest case to reach from the ports is a buffered word that differs from the RAM contents at the current pointer. This happens when the low pointer byte changes after a refill, or when a write lands without a trigger. The bench sets this up by triggering a refill at one pointer, then rewriting only offset 0EH to a different even address, and reading. A correct design returns the stale lane. The wrap corners are reached by loading 7FEH and streaming across the top of the array in both byte and word mode.

// File: rtl/sap_pkg.sv
package sap_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } sap_state_e;

    localparam logic [3:0] OFF_DATA    = 4'hC;
    localparam logic [3:0] OFF_DATA_HI = 4'hD;
    localparam logic [3:0] OFF_PTR_LO  = 4'hE;
    localparam logic [3:0] OFF_PTR_HI  = 4'hF;

    localparam int BIT_STEP = 7;
    localparam int BIT_DIR  = 6;
endpackage

// File: rtl/sap_ptr.sv
module sap_ptr #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [7:0]        lo_d,
    input  logic [ADDR_W-9:0] hi_d,
    input  logic              step_d,
    input  logic              dir_d,
    input  logic              adv_byte,
    input  logic              adv_word,
    output logic [ADDR_W-1:0] ptr_q,
    output logic              step_q,
    output logic              dir_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            step_q <= 1'b0;
            dir_q  <= 1'b0;
        end else if (ld_lo) begin
            ptr_q[7:0] <= lo_d;
        end else if (ld_hi) begin
            ptr_q[ADDR_W-1:8] <= hi_d;
            step_q <= step_d;
            dir_q  <= dir_d;
        end else if (adv_word) begin
            ptr_q <= {ptr_q[ADDR_W-1:1] + (ADDR_W-1)'(1), 1'b0};
        end else if (adv_byte) begin
            ptr_q <= ptr_q + ADDR_W'(1);
        end
    end
endmodule

// File: rtl/sap_ram.sv
module sap_ram #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic [ADDR_W-2:0] word_addr,
    input  logic [1:0]        lane_we,
    input  logic [15:0]       wdata,
    input  logic              fetch,
    output logic [15:0]       buf_q
);
    localparam int DEPTH = 2 ** (ADDR_W - 1);

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [7:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (lane_we[g]) mem[word_addr] <= wdata[g*8 +: 8];
            if (fetch)      buf_q[g*8 +: 8] <= mem[word_addr];
        end
    end
endmodule

// File: rtl/sap_ctrl.sv
module sap_ctrl
    import sap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic fetch_en
);
    sap_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (trig) state_d = ST_FETCH;
            ST_FETCH: state_d = trig ? ST_FETCH : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        fetch_en = (state_q == ST_FETCH);
    end
endmodule

// File: rtl/seq_ram_port.sv
module seq_ram_port
    import sap_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        io_rd,
    input  logic        io_wr,
    input  logic [3:0]  io_off,
    input  logic        io_wide,
    input  logic [15:0] io_wdata,
    output logic [15:0] io_rdata
);
    localparam int HI_W = ADDR_W - 8;
    localparam int PAD  = 6 - HI_W;

    logic [ADDR_W-1:0] ptr_q;
    logic              step_q, dir_q;
    logic              fetch_en;
    logic [15:0]       buf_q;
    logic              dat_rd, dat_wr, dat_acc, ld_lo, ld_hi, trig;
    logic [1:0]        lane_we;
    logic [15:0]       ram_wd;

    assign dat_rd  = io_rd && (io_off == OFF_DATA);
    assign dat_wr  = io_wr && (io_off == OFF_DATA);
    assign dat_acc = dat_rd || dat_wr;
    assign ld_lo   = io_wr && (io_off == OFF_PTR_LO);
    assign ld_hi   = io_wr && (io_off == OFF_PTR_HI);
    assign trig    = (ld_hi && io_wdata[BIT_DIR]) || (dat_rd && step_q);

    assign lane_we = !dat_wr ? 2'b00 : io_wide ? 2'b11 : ptr_q[0] ? 2'b10 : 2'b01;
    assign ram_wd  = io_wide ? io_wdata : {io_wdata[7:0], io_wdata[7:0]};

    sap_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_lo    (ld_lo),
        .ld_hi    (ld_hi),
        .lo_d     (io_wdata[7:0]),
        .hi_d     (io_wdata[HI_W-1:0]),
        .step_d   (io_wdata[BIT_STEP]),
        .dir_d    (io_wdata[BIT_DIR]),
        .adv_byte (dat_acc && step_q && !io_wide),
        .adv_word (dat_acc && step_q && io_wide),
        .ptr_q    (ptr_q),
        .step_q   (step_q),
        .dir_q    (dir_q)
    );

    sap_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk       (clk),
        .word_addr (ptr_q[ADDR_W-1:1]),
        .lane_we   (lane_we),
        .wdata     (ram_wd),
        .fetch     (fetch_en),
        .buf_q     (buf_q)
    );

    sap_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig),
        .fetch_en (fetch_en)
    );

    always_comb begin
        unique case (io_off)
            OFF_DATA:   io_rdata = io_wide ? buf_q
                                 : {8'h00, ptr_q[0] ? buf_q[15:8] : buf_q[7:0]};
            OFF_PTR_LO: io_rdata = {8'h00, ptr_q[7:0]};
            OFF_PTR_HI: io_rdata = {8'h00, step_q, dir_q, {PAD{1'b0}}, ptr_q[ADDR_W-1:8]};
            default:    io_rdata = 16'h0000;
        endcase
    end
endmodule

// File: rtl/sap_chk.sv
module sap_chk
    import sap_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_rd,
    input logic              io_wr,
    input logic [3:0]        io_off,
    input logic              io_wide,
    input logic              wr_dir,
    input logic [ADDR_W-1:0] ptr,
    input logic              step_on,
    input logic              fetch_en
);
    logic data_acc;
    assign data_acc = (io_rd || io_wr) && (io_off == OFF_DATA);

    // R4: byte step adds one, wrapping at the top
    assert_byte_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc && step_on && !io_wide |=> ptr == $past(ptr) + ADDR_W'(1));

    // R5: word step lands on the next even address
    assert_word_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc && step_on && io_wide |=>
        (ptr[0] == 1'b0) && (ptr[ADDR_W-1:1] == $past(ptr[ADDR_W-1:1]) + (ADDR_W-1)'(1)));

    // R6: stepping off keeps the pointer
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc && !step_on |=> $stable(ptr));

    // R7: direction-read pointer-high write triggers a buffer refill
    assert_prefetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr && (io_off == OFF_PTR_HI) && wr_dir |=> fetch_en);

    // R8: the lone high data offset touches nothing
    assert_idle_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd || io_wr) && (io_off == OFF_DATA_HI) |=> $stable(ptr) && !fetch_en);
endmodule

bind seq_ram_port sap_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .io_off   (io_off),
    .io_wide  (io_wide),
    .wr_dir   (io_wdata[sap_pkg::BIT_DIR]),
    .ptr      (ptr_q),
    .step_on  (step_q),
    .fetch_en (fetch_en)
);

// File: tb/sim_seq_ram_port.sv
`timescale 1ns/1ps
module sim_seq_ram_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_rd = 1'b0, io_wr = 1'b0, io_wide = 1'b0;
    logic [3:0]  io_off = 4'h0;
    logic [15:0] io_wdata = 16'h0;
    logic [15:0] io_rdata;

    always #2 clk = ~clk;

    seq_ram_port u0 (.*);

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // behavioural reference
    int mem [2048];
    int mptr = 0, mstep = 0, mdir = 0, mb_lo = 0, mb_hi = 0;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic refill();
        mb_lo = mem[mptr & 'h7FE];
        mb_hi = mem[mptr | 1];
    endtask

    task automatic advance(bit wide);
        if (mstep != 0) mptr = wide ? (((mptr >> 1) + 1) << 1) & 'h7FF : (mptr + 1) & 'h7FF;
    endtask

    task automatic wr(logic [3:0] off, bit wide, int d);
        @(negedge clk);
        io_off = off; io_wide = wide; io_wdata = d[15:0]; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        @(negedge clk);
        if (off == 4'hC) begin
            if (wide) begin
                mem[mptr & 'h7FE] = d & 'hFF;
                mem[mptr | 1] = (d >> 8) & 'hFF;
            end else mem[mptr] = d & 'hFF;
            advance(wide);
        end else if (off == 4'hE) mptr = (mptr & 'h700) | (d & 'hFF);
        else if (off == 4'hF) begin
            mptr = (mptr & 'hFF) | ((d & 7) << 8);
            mstep = (d >> 7) & 1;
            mdir = (d >> 6) & 1;
            if (mdir != 0) refill();
        end
    endtask

    task automatic rd(string req, logic [3:0] off, bit wide);
        int exp;
        @(negedge clk);
        io_off = off; io_wide = wide; io_rd = 1'b1;
        #1;
        if (off == 4'hC) exp = wide ? (mb_hi << 8) | mb_lo : ((mptr & 1) != 0 ? mb_hi : mb_lo);
        else if (off == 4'hE) exp = mptr & 'hFF;
        else if (off == 4'hF) exp = (mstep << 7) | (mdir << 6) | (mptr >> 8);
        else exp = 0;
        check(req, int'(io_rdata), exp);
        @(negedge clk);
        io_rd = 1'b0;
        @(negedge clk);
        if (off == 4'hC && mstep != 0) begin
            advance(wide);
            refill();
        end
    endtask

    task automatic set_ptr(int p, int ctl);
        wr(4'hE, 0, p & 'hFF);
        wr(4'hF, 0, ctl | (p >> 8));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        rd("R1", 4'hE, 0);
        rd("R1", 4'hF, 0);
        rd("R8 unused offset", 4'h3, 0);
        // R2 readback, bits 5..3 ignored
        set_ptr('h5A3, 'h38);
        rd("R2", 4'hE, 0);
        rd("R2", 4'hF, 0);
        // R3 / R4 byte write stream
        set_ptr('h010, 'h80);
        for (int i = 0; i < 8; i++) wr(4'hC, 0, 'hA0 + i * 3);
        rd("R4", 4'hE, 0);
        // R7 / R9 / R3 byte read stream
        set_ptr('h010, 'hC0);
        for (int i = 0; i < 8; i++) rd("R9 R3", 4'hC, 0);
        rd("R4", 4'hE, 0);
        // R4 wrap
        set_ptr('h7FE, 'h80);
        for (int i = 0; i < 3; i++) wr(4'hC, 0, 'h31 + i);
        rd("R4 wrap", 4'hE, 0);
        rd("R4 wrap", 4'hF, 0);
        set_ptr('h7FE, 'hC0);
        for (int i = 0; i < 3; i++) rd("R4 wrap R7", 4'hC, 0);
        // R5 word write and aligned read
        set_ptr('h020, 'h80);
        for (int i = 0; i < 4; i++) wr(4'hC, 1, 'h1100 * (i + 1) + 'h0E);
        rd("R5", 4'hE, 0);
        set_ptr('h021, 'hC0);
        rd("R5 align", 4'hC, 1);
        rd("R5", 4'hE, 0);
        rd("R5 lanes", 4'hC, 1);
        set_ptr('h023, 'hC0);
        rd("R5 odd byte", 4'hC, 0);
        // R5 wrap
        set_ptr('h7FF, 'h80);
        wr(4'hC, 1, 'hBEEF);
        rd("R5 wrap", 4'hE, 0);
        rd("R5 wrap", 4'hF, 0);
        // R6 no stepping
        set_ptr('h012, 'h40);
        rd("R6", 4'hC, 0);
        rd("R6", 4'hC, 0);
        rd("R6", 4'hE, 0);
        wr(4'hC, 0, 'h77);
        rd("R6", 4'hE, 0);
        // R8 lone high data offset
        set_ptr('h016, 'h80);
        wr(4'hD, 0, 'h55);
        wr(4'hD, 1, 'h5555);
        rd("R8", 4'hE, 0);
        rd("R8", 4'hD, 0);
        set_ptr('h016, 'hC0);
        rd("R8 mem", 4'hC, 0);
        // R10 pointer-low write does not refill
        set_ptr('h010, 'h40);
        wr(4'hE, 0, 'h14);
        rd("R10", 4'hC, 0);
        rd("R10", 4'hC, 1);
        done = 1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule